// File: doc/BRIEF.md
# SATA Receive Continuation Filter

This block sits on the receive side of a SATA link layer, between the PHY dword stream and the link state machine. Each incoming dword comes with a 4-bit K-character flag. The block works out whether the dword is a known primitive and follows the continuation mechanism. After a continuation primitive, the sender may fill the line with scrambled junk instead of repeating its last primitive. The filter hides that junk and the continuation marker itself. In their place it presents the primitive that is still in force, so the link state machine always sees a clean, repeated primitive.

Both sides use valid/ready. The filter has no buffer: one accepted input gives at most one output in the same cycle. The output comes through logic only, from the current input and the held state. An upstream source must keep `in_valid`, `in_data` and `in_kflag` steady while `in_valid` is high and `in_ready` is low. The only case where an input is consumed without an output is a dropped ALIGN. In that case `in_ready` is high whatever `out_ready` is. The `align_keep` control pin selects whether ALIGN is dropped or forwarded.

Top module: `sata_cont_filter`

## Requirements
- R1: After reset, continuation is inactive and the held primitive is SYNC (0xB5B5957C, flag 0001). A continuation dword received first is therefore output as SYNC with flag 0001.
- R2: A dword whose flag is nonzero but whose value is not in the primitive table is treated as data. Outside continuation it passes unchanged, including its flag.
- R3: A continuation primitive (0x9999AA7C, nonzero flag) sets continuation active. It is never forwarded; the held primitive and its flag are output in its place.
- R4: While continuation is active, every accepted data dword is replaced at the output by the held primitive and its flag.
- R5: Any primitive other than continuation or ALIGN is forwarded unchanged, becomes the held primitive, and clears continuation. The table also holds SYNC, R_RDY 0x4A4A957C, R_OK 0x3535B57C and HOLDA 0x9595AA7C.
- R6: ALIGN (0x7B4A4ABC, nonzero flag) changes neither the continuation state nor the held primitive. With `align_keep` high it is forwarded unchanged. With `align_keep` low it is consumed and produces no output.
- R7: A data dword received outside continuation passes to the output unchanged.
- R8: `out_valid` equals `in_valid` except for a dropped ALIGN. `in_ready` equals `out_ready` except for a dropped ALIGN, when it is 1. State changes only on an accepted input.
- R9: A dword whose value equals a primitive but whose flag is 0000 is data and is handled as in R4 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| align_keep | input | 1 | 1 forwards ALIGN, 0 drops it |
| in_valid | input | 1 | Input dword offered |
| in_ready | output | 1 | Input dword accepted this cycle when valid |
| in_data | input | 32 | Received dword |
| in_kflag | input | 4 | K-character flag per byte |
| out_valid | output | 1 | Output dword offered |
| out_ready | input | 1 | Downstream accepts the output |
| out_data | output | 32 | Filtered dword |
| out_kflag | output | 4 | Flag of the filtered dword |

## Verification
The assertions assume the upstream side keeps its offer steady while it stalls, and that `align_keep` does not change while a dword is pending. The bench therefore picks a new word and a new `align_keep` only after the previous word has been accepted or when nothing is offered. Random back-pressure and random gaps in valid then test stalls without breaking that rule. The word mix covers continuation runs, known primitives, junk with and without flags, and primitive values sent with a zero flag.

// File: rtl/sata_cont_pkg.sv
package sata_cont_pkg;
  localparam int DW       = 32;
  localparam int KW       = 4;
  localparam int NUM_PRIM = 6;

  typedef logic [DW-1:0] dword_t;
  typedef logic [KW-1:0] kflag_t;

  localparam dword_t PRIM_ALIGN = 32'h7B4A4ABC;
  localparam dword_t PRIM_CONT  = 32'h9999AA7C;
  localparam dword_t PRIM_SYNC  = 32'hB5B5957C;
  localparam dword_t PRIM_RRDY  = 32'h4A4A957C;
  localparam dword_t PRIM_ROK   = 32'h3535B57C;
  localparam dword_t PRIM_HOLDA = 32'h9595AA7C;
  localparam kflag_t KFLAG_PRIM = 4'b0001;

  localparam dword_t PRIM_TABLE [NUM_PRIM] = '{
    PRIM_SYNC, PRIM_RRDY, PRIM_ROK, PRIM_HOLDA, PRIM_ALIGN, PRIM_CONT
  };

  typedef enum logic [1:0] {
    CLS_DATA  = 2'd0,
    CLS_CONT  = 2'd1,
    CLS_ALIGN = 2'd2,
    CLS_PRIM  = 2'd3
  } cls_e;
endpackage

// File: rtl/sata_cont_classify.sv
module sata_cont_classify
  import sata_cont_pkg::*;
(
  input  dword_t data,
  input  kflag_t kflag,
  output cls_e   cls
);
  logic [NUM_PRIM-1:0] hit;

  for (genvar i = 0; i < NUM_PRIM; i++) begin : g_match
    assign hit[i] = (data == PRIM_TABLE[i]);
  end

  logic is_prim;
  assign is_prim = (|hit) && (|kflag);

  always_comb begin
    if (!is_prim)                  cls = CLS_DATA;
    else if (data == PRIM_CONT)    cls = CLS_CONT;
    else if (data == PRIM_ALIGN)   cls = CLS_ALIGN;
    else                           cls = CLS_PRIM;
  end
endmodule

// File: rtl/sata_cont_track.sv
module sata_cont_track
  import sata_cont_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  cls_e   cls,
  input  dword_t data,
  input  kflag_t kflag,
  output logic   cont_active,
  output dword_t held_data,
  output kflag_t held_kflag
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cont_active <= 1'b0;
      held_data   <= PRIM_SYNC;
      held_kflag  <= KFLAG_PRIM;
    end else if (accept) begin
      case (cls)
        CLS_CONT: cont_active <= 1'b1;
        CLS_PRIM: begin
          cont_active <= 1'b0;
          held_data   <= data;
          held_kflag  <= kflag;
        end
        default: ;
      endcase
    end
  end

  AST_CONT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cls == CLS_CONT |=> cont_active); // R3
  AST_PRIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cls == CLS_PRIM |=> !cont_active && held_data == $past(data)); // R5
  AST_ALIGN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cls == CLS_ALIGN |=> $stable(cont_active) && $stable(held_data)); // R6
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cont_active) && $stable(held_data) && $stable(held_kflag)); // R8
  AST_HELD_PRIM: assert property (@(posedge clk) disable iff (!rst_n)
    held_kflag != '0 && held_data != PRIM_CONT && held_data != PRIM_ALIGN); // R5
endmodule

// File: rtl/sata_cont_mux.sv
module sata_cont_mux
  import sata_cont_pkg::*;
(
  input  logic   in_valid,
  input  cls_e   cls,
  input  dword_t in_data,
  input  kflag_t in_kflag,
  input  logic   align_keep,
  input  logic   cont_active,
  input  dword_t held_data,
  input  kflag_t held_kflag,
  output logic   drop,
  output logic   out_valid,
  output dword_t out_data,
  output kflag_t out_kflag
);
  logic use_held;

  assign drop      = in_valid && (cls == CLS_ALIGN) && !align_keep;
  assign out_valid = in_valid && !drop;
  assign use_held  = (cls == CLS_CONT) || (cls == CLS_DATA && cont_active);

  always_comb begin
    if (use_held) begin
      out_data  = held_data;
      out_kflag = held_kflag;
    end else begin
      out_data  = in_data;
      out_kflag = in_kflag;
    end
  end
endmodule

// File: rtl/sata_cont_filter.sv
module sata_cont_filter
  import sata_cont_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          align_keep,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic [KW-1:0] in_kflag,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [KW-1:0] out_kflag
);
  cls_e   cls;
  logic   drop, accept, cont_active;
  dword_t held_data;
  kflag_t held_kflag;

  sata_cont_classify u_cls (
    .data  (in_data),
    .kflag (in_kflag),
    .cls   (cls)
  );

  assign in_ready = out_ready || drop;
  assign accept   = in_valid && in_ready;

  sata_cont_track u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .cls         (cls),
    .data        (in_data),
    .kflag       (in_kflag),
    .cont_active (cont_active),
    .held_data   (held_data),
    .held_kflag  (held_kflag)
  );

  sata_cont_mux u_mux (
    .in_valid    (in_valid),
    .cls         (cls),
    .in_data     (in_data),
    .in_kflag    (in_kflag),
    .align_keep  (align_keep),
    .cont_active (cont_active),
    .held_data   (held_data),
    .held_kflag  (held_kflag),
    .drop        (drop),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_kflag   (out_kflag)
  );

  AST_CONT_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_kflag != '0 |-> out_data != PRIM_CONT); // R3
  AST_NO_DATA_IN_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cont_active |-> out_kflag != '0); // R4
  AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready); // R8
  AST_INPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready |=> in_valid && $stable(in_data) && $stable(in_kflag)); // R8
endmodule

// File: tb/sata_cont_filter_test.sv
module sata_cont_filter_test;
  import sata_cont_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0, align_keep = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [31:0] in_data = '0, out_data;
  logic [3:0]  in_kflag = '0, out_kflag;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_cont = 0;
  logic [31:0] m_held = 32'hB5B5957C;
  logic [3:0]  m_heldk = 4'b0001;
  string       tag_force = "";

  always #5 clk = ~clk;

  sata_cont_filter uut (
    .clk(clk), .rst_n(rst_n), .align_keep(align_keep),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_kflag(in_kflag),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_kflag(out_kflag)
  );

  function automatic int kind_of(logic [31:0] d, logic [3:0] k);
    // 0 data, 1 continuation, 2 align, 3 other primitive
    if (k == 4'd0) return 0;
    case (d)
      32'h9999AA7C: return 1;
      32'h7B4A4ABC: return 2;
      32'hB5B5957C, 32'h4A4A957C, 32'h3535B57C, 32'h9595AA7C: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, string what, logic [35:0] act, logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: compare outputs against the model, then advance the model
  task automatic step();
    int kd;
    bit drop, ev, er;
    logic [31:0] ed;
    logic [3:0]  ek;
    string tag;
    #2;
    kd = kind_of(in_data, in_kflag);
    drop = in_valid && kd == 2 && !align_keep;
    ev = in_valid && !drop;
    er = out_ready || drop;
    ed = in_data; ek = in_kflag;
    if (kd == 1 || (kd == 0 && m_cont)) begin ed = m_held; ek = m_heldk; end
    if (tag_force != "") tag = tag_force;
    else if (kd == 1) tag = "R3";
    else if (kd == 2) tag = "R6";
    else if (kd == 3) tag = "R5";
    else if (m_cont) tag = "R4";
    else if (in_kflag != 0 && (in_data == 32'h9999AA7C || in_data == 32'hB5B5957C)) tag = "R9";
    else if (in_kflag != 0) tag = "R2";
    else if (in_data == 32'h9999AA7C || in_data == 32'hB5B5957C) tag = "R9";
    else tag = "R7";
    check("R8", "out_valid", {35'd0, out_valid}, {35'd0, ev});
    check("R8", "in_ready", {35'd0, in_ready}, {35'd0, er});
    if (ev) check(tag, "out", {out_kflag, out_data}, {ek, ed});
    if (in_valid && er) begin
      if (kd == 1) m_cont = 1;
      else if (kd == 3) begin m_cont = 0; m_held = in_data; m_heldk = in_kflag; end
    end
    @(negedge clk);
  endtask

  task automatic send(logic [31:0] d, logic [3:0] k, bit keep = 0);
    in_valid = 1; in_data = d; in_kflag = k; align_keep = keep; out_ready = 1;
    step();
    in_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset out_valid", {35'd0, out_valid}, 36'd0);
    rst_n = 1;
    @(negedge clk);
    tag_force = "R1"; send(32'h9999AA7C, 4'b0001); tag_force = "";
    send(32'hDEADBEEF, 4'h0);                   // junk in continuation, R4
    send(32'h4A4A957C, 4'b0001);                // R5 clears
    send(32'h4A4A957C, 4'b0001);
    send(32'h01020304, 4'h0);                   // R7 passes
    send(32'h9999AA7C, 4'b0001);                // R3
    send(32'h11111111, 4'h0);
    send(32'h22222222, 4'h0);
    send(32'h7B4A4ABC, 4'b0001, 0);             // R6 dropped
    send(32'h33333333, 4'h0);                   // still in continuation
    send(32'h7B4A4ABC, 4'b0001, 1);             // R6 kept
    send(32'h44444444, 4'h0);
    send(32'h9595AA7C, 4'b0001);                // R5
    send(32'h9999AA7C, 4'h0);                   // R9 data
    send(32'h12345678, 4'b0001);                // R2 unknown K
    send(32'h3535B57C, 4'b0001);
    // random phase with back-pressure; offer held until accepted
    in_valid = 0;
    for (int c = 0; c < 4000; c++) begin
      out_ready = ($urandom_range(0, 3) != 0);
      if (!in_valid || in_ready) begin
        int r;
        in_valid = ($urandom_range(0, 4) != 0);
        align_keep = $urandom_range(0, 1);
        r = $urandom_range(0, 9);
        in_kflag = 4'b0001;
        case (r)
          0, 1: in_data = 32'h9999AA7C;
          2: in_data = 32'h7B4A4ABC;
          3: in_data = 32'hB5B5957C;
          4: in_data = 32'h4A4A957C;
          5: in_data = 32'h9595AA7C;
          6: begin in_data = 32'h9999AA7C; in_kflag = 4'h0; end
          7: in_data = $urandom();
          default: begin in_data = $urandom(); in_kflag = 4'h0; end
        endcase
      end
      step();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule